// File: doc/BRIEF.md
# Frame Correlation Scale and Stop Unit

This block sits beside an iterative soft-input soft-output decoder pair. For every half-iteration it receives, as a stream, one frame of signed fixed-point sample pairs: the a-posteriori log-likelihood ratio and the extrinsic log-likelihood ratio of the same bit. At the end of the frame it measures how strongly the two sequences agree. The measure is the squared correlation coefficient of the two sequences after each has had its frame mean removed. The result is an unsigned Q1.15 value between 0 and 1.0. It serves two purposes. It is the gain applied to later extrinsic values bound for the other constituent decoder. It also raises a stop flag once it reaches 0.98.

The means are never formed explicitly. Raw sums, sums of squares and the cross sum are accumulated in one pass. The centred terms are then derived with every term multiplied by the sample count N, which cancels in the ratio. A restoring divider produces the 16 quotient bits, one per clock. A separate scale factor is kept for each constituent decoder. Every incoming extrinsic sample is multiplied by the factor of the decoder named on that sample and appears one clock later. A frame end that arrives while a coefficient is still being computed is not evaluated.

Top module: `corr_scale_unit`

## Requirements
- R1: After reset, `done`, `stop` and `extValid` are low, `coef` is 0, and both per-decoder scale factors equal 1.0 (32768), so a scaled sample equals its input.
- R2: A valid sample with `inSof` high starts a new frame, and each later valid sample adds to it. For a frame of N samples, with Cxy = N·Σxy − Σx·Σy, Cxx = N·Σx² − (Σx)² and Cyy = N·Σy² − (Σy)² (x = a-posteriori, y = extrinsic), the result is `coef` = floor(32768·Cxy² / (Cxx·Cyy)).
- R3: `coef` is unsigned Q1.15 and never exceeds 32768. The sign of the correlation is lost, so a frame with y = −x gives exactly 32768.
- R4: If Cxx or Cyy is zero, `coef` is forced to 32768 and `stop` is high.
- R5: `stop` equals (`coef` ≥ 32113), the Q1.15 value of 0.98. `stop`, `coef` and `coefDec` hold their values until the next result.
- R6: `done` is high for exactly one cycle, beginning 18 clock edges after the edge that accepts the sample with `inEof`. `coefDec` then gives the decoder index that was present on the first sample of that frame.
- R7: Each valid input sample gives `extValid` high one cycle later, with `extScaled` = floor(inExt·c / 32768), where c is the current scale factor of the decoder named by `inDec` on that sample.
- R8: A result updates the scale factor only for its own decoder index. The other decoder's factor is unchanged.
- R9: A sample accepted on the same clock edge as the scale factor update for its decoder is scaled by the old factor. The next sample is scaled by the new factor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Sample pair present |
| inSof | input | 1 | First sample of a frame |
| inEof | input | 1 | Last sample of a frame |
| inDec | input | DW | Constituent decoder index of the sample |
| inApp | input | W | Signed a-posteriori value |
| inExt | input | W | Signed extrinsic value |
| extValid | output | 1 | Scaled extrinsic sample present |
| extScaled | output | W | Extrinsic value times the decoder's scale factor |
| done | output | 1 | One-cycle strobe: new coefficient available |
| coef | output | 16 | Squared correlation, unsigned Q1.15 |
| coefDec | output | DW | Decoder index the coefficient belongs to |
| stop | output | 1 | Coefficient at or above 0.98 |

## Verification
Two functions can act in the same cycle: the commit of a new coefficient into a decoder's scale register, and the scaling of an incoming extrinsic sample for that same decoder. The bench lines up a probe sample so that it is accepted on the exact edge where `done` is produced. It then sends a second probe on the following edge. The first scaled output must match the previous factor and the second must match the new one. Each expected value is computed from the bench's own floor-of-product arithmetic.

// File: rtl/corr_pkg.sv
package corr_pkg;
  localparam int QB = 16;
  localparam logic [QB-1:0] COEF_ONE = 16'd32768;
  localparam logic [QB-1:0] COEF_STOP = 16'd32113;

  typedef struct packed {
    logic capture;
    logic latchCent;
    logic loadDiv;
    logic divStep;
    logic firstStep;
    logic commit;
  } ctrlStrobes_t;
endpackage

// File: rtl/corr_ctrl.sv
module corr_ctrl
  import corr_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         frameEnd,
  output ctrlStrobes_t st
);
  localparam int SCW = $clog2(QB);

  typedef enum logic [1:0] {S_IDLE, S_CENT, S_PROD, S_DIV} ctrlState_e;

  ctrlState_e state;
  logic [SCW-1:0] stepCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      stepCnt <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (frameEnd) state <= S_CENT;
        S_CENT: state <= S_PROD;
        S_PROD: begin
          state   <= S_DIV;
          stepCnt <= '0;
        end
        S_DIV: begin
          if (stepCnt == SCW'(QB - 1)) state <= S_IDLE;
          stepCnt <= stepCnt + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    st.capture   = (state == S_IDLE) && frameEnd;
    st.latchCent = (state == S_CENT);
    st.loadDiv   = (state == S_PROD);
    st.divStep   = (state == S_DIV);
    st.firstStep = (state == S_DIV) && (stepCnt == '0);
    st.commit    = (state == S_DIV) && (stepCnt == SCW'(QB - 1));
  end
endmodule

// File: rtl/corr_dp.sv
module corr_dp
  import corr_pkg::*;
#(
  parameter int W    = 8,
  parameter int NMAX = 6144,
  parameter int NDEC = 2,
  localparam int DW  = (NDEC > 1) ? $clog2(NDEC) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic                inSof,
  input  logic [DW-1:0]       inDec,
  input  logic signed [W-1:0] inApp,
  input  logic signed [W-1:0] inExt,
  input  ctrlStrobes_t        st,
  output logic                extValid,
  output logic signed [W-1:0] extScaled,
  output logic                done,
  output logic [QB-1:0]       coef,
  output logic [DW-1:0]       coefDec,
  output logic                stop
);
  localparam int CW   = $clog2(NMAX + 1);
  localparam int AW1  = W + CW;
  localparam int AW2  = 2 * W + CW;
  localparam int CENW = 2 * AW1 + 2;
  localparam int PW   = 2 * CENW;
  localparam int RW   = PW + 1;
  localparam int SW   = W + QB + 1;

  // raw moment accumulators
  logic [CW-1:0]          sampleCnt;
  logic signed [AW1-1:0]  sumX, sumY;
  logic signed [AW2-1:0]  sumXX, sumYY, sumXY;
  logic signed [2*W-1:0]  termXX, termYY, termXY;

  assign termXX = inApp * inApp;
  assign termYY = inExt * inExt;
  assign termXY = inApp * inExt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampleCnt <= '0;
      sumX <= '0; sumY <= '0;
      sumXX <= '0; sumYY <= '0; sumXY <= '0;
    end else if (inValid) begin
      if (inSof) begin
        sampleCnt <= CW'(1);
        sumX  <= AW1'(inApp);
        sumY  <= AW1'(inExt);
        sumXX <= AW2'(termXX);
        sumYY <= AW2'(termYY);
        sumXY <= AW2'(termXY);
      end else begin
        sampleCnt <= sampleCnt + 1'b1;
        sumX  <= sumX + AW1'(inApp);
        sumY  <= sumY + AW1'(inExt);
        sumXX <= sumXX + AW2'(termXX);
        sumYY <= sumYY + AW2'(termYY);
        sumXY <= sumXY + AW2'(termXY);
      end
    end
  end

  // decoder index of the open frame and of the frame under evaluation
  logic [DW-1:0] frameDec, pipeDec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameDec <= '0;
      pipeDec  <= '0;
    end else begin
      if (inValid && inSof) frameDec <= inDec;
      if (st.capture) pipeDec <= inSof ? inDec : frameDec;
    end
  end

  // centred terms, all scaled by N so that no division by N is needed
  logic signed [CENW-1:0] cenXY, cenXX, cenYY;
  logic signed [CENW-1:0] cntS;

  assign cntS = CENW'($signed({1'b0, sampleCnt}));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cenXY <= '0; cenXX <= '0; cenYY <= '0;
    end else if (st.latchCent) begin
      cenXY <= cntS * CENW'(sumXY) - CENW'(sumX) * CENW'(sumY);
      cenXX <= cntS * CENW'(sumXX) - CENW'(sumX) * CENW'(sumX);
      cenYY <= cntS * CENW'(sumYY) - CENW'(sumY) * CENW'(sumY);
    end
  end

  // restoring divider, one quotient bit per step, integer bit first
  logic [PW-1:0]  numW, denW;
  logic [PW-1:0]  divDen;
  logic [RW-1:0]  divRem, trialRem, remNext;
  logic [QB-1:0]  quo, quoNext, coefNext;
  logic           zeroVar, trialGe;

  assign numW = PW'(cenXY) * PW'(cenXY);
  assign denW = PW'(cenXX) * PW'(cenYY);

  always_comb begin
    trialRem = st.firstStep ? divRem : (divRem << 1);
    trialGe  = (trialRem >= {1'b0, divDen});
    remNext  = trialGe ? (trialRem - {1'b0, divDen}) : trialRem;
    quoNext  = {quo[QB-2:0], trialGe};
    coefNext = zeroVar ? COEF_ONE : quoNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divRem  <= '0;
      divDen  <= '0;
      quo     <= '0;
      zeroVar <= 1'b0;
    end else if (st.loadDiv) begin
      divRem  <= {1'b0, numW};
      divDen  <= denW;
      quo     <= '0;
      zeroVar <= (cenXX == '0) || (cenYY == '0);
    end else if (st.divStep) begin
      divRem <= remNext;
      quo    <= quoNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      done    <= 1'b0;
      coef    <= '0;
      coefDec <= '0;
      stop    <= 1'b0;
    end else begin
      done <= st.commit;
      if (st.commit) begin
        coef    <= coefNext;
        coefDec <= pipeDec;
        stop    <= (coefNext >= COEF_STOP);
      end
    end
  end

  // per-decoder scale factors
  logic [QB-1:0] scaleBank [NDEC];

  for (genvar g = 0; g < NDEC; g++) begin : gBank
    always_ff @(posedge clk) begin
      if (!rstN) scaleBank[g] <= COEF_ONE;
      else if (st.commit && (pipeDec == DW'(g))) scaleBank[g] <= coefNext;
    end
  end

  logic [QB-1:0]        scaleSel;
  logic signed [SW-1:0] scaleProd;

  assign scaleSel  = scaleBank[inDec];
  assign scaleProd = SW'(inExt) * $signed({1'b0, scaleSel});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      extValid  <= 1'b0;
      extScaled <= '0;
    end else begin
      extValid <= inValid;
      if (inValid) extScaled <= W'(scaleProd >>> (QB - 1));
    end
  end
endmodule

// File: rtl/corr_scale_unit.sv
module corr_scale_unit
  import corr_pkg::*;
#(
  parameter int W    = 8,
  parameter int NMAX = 6144,
  parameter int NDEC = 2,
  localparam int DW  = (NDEC > 1) ? $clog2(NDEC) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic                inSof,
  input  logic                inEof,
  input  logic [DW-1:0]       inDec,
  input  logic signed [W-1:0] inApp,
  input  logic signed [W-1:0] inExt,
  output logic                extValid,
  output logic signed [W-1:0] extScaled,
  output logic                done,
  output logic [15:0]         coef,
  output logic [DW-1:0]       coefDec,
  output logic                stop
);
  ctrlStrobes_t strobes;

  corr_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .frameEnd (inValid && inEof),
    .st       (strobes)
  );

  corr_dp #(.W(W), .NMAX(NMAX), .NDEC(NDEC)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .inSof     (inSof),
    .inDec     (inDec),
    .inApp     (inApp),
    .inExt     (inExt),
    .st        (strobes),
    .extValid  (extValid),
    .extScaled (extScaled),
    .done      (done),
    .coef      (coef),
    .coefDec   (coefDec),
    .stop      (stop)
  );
endmodule

// File: rtl/corr_scale_chk.sv
module corr_scale_chk #(
  parameter int W  = 8,
  parameter int DW = 1
) (
  input logic                clk,
  input logic                rstN,
  input logic                inValid,
  input logic signed [W-1:0] inExt,
  input logic                extValid,
  input logic signed [W-1:0] extScaled,
  input logic                done,
  input logic [15:0]         coef,
  input logic [DW-1:0]       coefDec,
  input logic                stop
);
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R5
  stop_thresh_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (stop == (coef >= 16'd32113)));

  // R3
  coef_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (coef <= 16'd32768));

  // R5
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(coef) && $stable(stop) && $stable(coefDec)));

  // R7
  ext_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> extValid);

  // R7
  ext_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !extValid);

  // R7
  ext_shrink_chk: assert property (@(posedge clk) disable iff (!rstN)
    (extValid && ($past(inExt) >= 0)) |-> ((extScaled >= 0) && (extScaled <= $past(inExt))));
endmodule

bind corr_scale_unit corr_scale_chk #(.W(W), .DW(DW)) uChk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inExt(inExt),
  .extValid(extValid), .extScaled(extScaled), .done(done),
  .coef(coef), .coefDec(coefDec), .stop(stop)
);

// File: tb/tb_corr_scale_unit.sv
module tb_corr_scale_unit;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, inSof = 1'b0, inEof = 1'b0;
  logic [0:0] inDec = '0;
  logic signed [W-1:0] inApp = '0, inExt = '0;
  logic extValid, done, stop;
  logic signed [W-1:0] extScaled;
  logic [15:0] coef;
  logic [0:0] coefDec;

  int checks = 0;
  int fails = 0;
  int model [2] = '{32768, 32768};
  int unsigned seed = 32'h1234_5678;

  always #2 clk = ~clk;

  corr_scale_unit dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSof(inSof), .inEof(inEof),
    .inDec(inDec), .inApp(inApp), .inExt(inExt), .extValid(extValid),
    .extScaled(extScaled), .done(done), .coef(coef), .coefDec(coefDec), .stop(stop)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rnd(input int span);
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 16) % span);
  endfunction

  function automatic int scaled(input int e, input int c);
    return (e * c) >>> 15;
  endfunction

  task automatic idle();
    inValid = 1'b0; inSof = 1'b0; inEof = 1'b0;
  endtask

  // kind: 0 y=x, 1 y=-x, 2 y constant, 3 y=x/2+noise, 4 independent
  task automatic runFrame(input int dec, input int n, input int kind, input bit collide,
                          input int probe, input string req);
    longint sx = 0, sy = 0, sxx = 0, syy = 0, sxy = 0;
    longint cxy, cxx, cyy;
    logic signed [127:0] cxyW, cxxW, cyyW;
    logic [127:0] num, den;
    int expCoef, oldC;
    bit early = 0;
    for (int i = 0; i < n; i++) begin
      int a, e;
      a = rnd(201) - 100;
      case (kind)
        0: e = a;
        1: e = -a;
        2: e = 5;
        3: e = a / 2 + rnd(7) - 3;
        default: e = rnd(201) - 100;
      endcase
      sx += a; sy += e; sxx += a * a; syy += e * e; sxy += a * e;
      @(negedge clk);
      inValid = 1'b1; inSof = (i == 0); inEof = (i == n - 1);
      inDec = dec[0]; inApp = W'(a); inExt = W'(e);
    end
    cxy = n * sxy - sx * sy;
    cxx = n * sxx - sx * sx;
    cyy = n * syy - sy * sy;
    cxyW = 128'(cxy); cxxW = 128'(cxx); cyyW = 128'(cyy);
    num = cxyW * cxyW;
    den = cxxW * cyyW;
    if (cxx == 0 || cyy == 0) expCoef = 32768;
    else expCoef = int'((num << 15) / den);
    oldC = model[dec];
    for (int k = 1; k <= 18; k++) begin
      @(negedge clk);
      if (k == 1) idle();
      if (done) early = 1;
      if (k == 18 && collide) begin
        inValid = 1'b1; inSof = 1'b1; inEof = 1'b0;
        inDec = dec[0]; inApp = '0; inExt = W'(probe);
      end
    end
    chk({req, " R6 no early done"}, early, 0);
    @(negedge clk);
    chk({req, " R6 done timing"}, done, 1);
    chk({req, " R2 coef"}, coef, expCoef);
    chk({req, " R5 stop"}, stop, (expCoef >= 32113) ? 1 : 0);
    chk({req, " R6 coefDec"}, coefDec, dec);
    model[dec] = expCoef;
    if (collide) begin
      chk({req, " R9 same-edge sample uses old factor"}, extScaled, scaled(probe, oldC));
      inSof = 1'b0; inExt = W'(-probe);
      @(negedge clk);
      chk({req, " R9 next sample uses new factor"}, extScaled, scaled(-probe, expCoef));
      chk({req, " R6 done one cycle"}, done, 0);
      idle();
    end else begin
      @(negedge clk);
      chk({req, " R6 done one cycle"}, done, 0);
    end
  endtask

  task automatic probeScale(input int dec, input int e, input string req);
    @(negedge clk);
    inValid = 1'b1; inSof = 1'b0; inEof = 1'b0; inDec = dec[0]; inApp = '0; inExt = W'(e);
    @(negedge clk);
    idle();
    chk({req, " R7 extValid"}, extValid, 1);
    chk({req, " scaled value"}, extScaled, scaled(e, model[dec]));
  endtask

  task automatic testReset();
    chk("R1 done", done, 0);
    chk("R1 stop", stop, 0);
    chk("R1 extValid", extValid, 0);
    chk("R1 coef", coef, 0);
    probeScale(0, -77, "R1 unity dec0");
    probeScale(1, 99, "R1 unity dec1");
  endtask

  task automatic testCorrelated();
    runFrame(0, 32, 0, 0, 0, "R2 identical");
    chk("R3 identical equals one", coef, 32768);
    runFrame(1, 40, 1, 0, 0, "R3 anti");
    chk("R3 anti equals one", coef, 32768);
  endtask

  task automatic testFlat();
    runFrame(0, 24, 2, 0, 0, "R4 flat");
    chk("R4 forced one", coef, 32768);
    chk("R4 forced stop", stop, 1);
  endtask

  task automatic testPartial();
    runFrame(1, 48, 3, 1, 90, "R2 partial");
    probeScale(1, -101, "R7 dec1 after update");
    probeScale(0, -101, "R8 dec0 unchanged");
    runFrame(0, 64, 4, 1, -120, "R2 noise");
    chk("R5 noise below threshold", stop, 0);
    probeScale(0, 127, "R7 dec0 after update");
    probeScale(1, 127, "R8 dec1 unchanged");
  endtask

  task automatic testLong();
    runFrame(1, 6144, 3, 0, 0, "R2 full length");
    probeScale(1, -128, "R7 full length scale");
  endtask

  initial begin
    #(4 * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testCorrelated();
    testFlat();
    testPartial();
    testLong();
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule